// File: doc/BRIEF.md
# Memory Error Status Capture Unit

This unit sits next to a tightly-coupled RAM controller and turns one-cycle error pulses from the memory datapath into sticky status flags, captured fault addresses and level interrupts. It takes six event sources: corrected single-bit errors, uncorrectable multi-bit errors, read-address parity failures, write-address parity failures, redundant address-decode mismatches, and compare-element failures seen during self-test. Single-bit errors do not set a flag on every pulse. They advance a counter, and the flag sets only when the counter reaches a programmable threshold.

A flag that is already set blocks two things: it stops its address register from being overwritten, so the first failing address is kept, and it stops any new interrupt from being raised. Software reads the flags and addresses over a simple word-indexed register bus. It clears a flag by writing 1 to its bit during a privileged access, and that clear re-arms both capture and interrupt generation. Register map, as word index (byte offset / 4): 0 control, 1 threshold, 2 count, 4 status (byte offset 0x10), 5 read-parity address, 6 write-parity address, 7 uncorrectable address. Word 3 reads as zero.

Top module: `memerr_status_unit`

## Requirements
- R1: After reset every status flag, the single-bit counter, the threshold, the control bits, all captured addresses and all four interrupts are zero.
- R2: Status bits are single-bit error threshold at bit 0, address decode fail at bit 2, compare-logic fail at bit 4, multi-bit error at bit 5, read-address parity at bit 8 and write-address parity at bit 9. All other status bits read 0 and ignore writes.
- R3: A status write clears the flags whose data bits are 1, and only when bus_priv is high. Writing 0, or writing without privilege, leaves every flag unchanged. Writes to the control and threshold registers also take effect only with privilege.
- R4: A parity event loads its address register (read: word 5, write: word 6) only while its own parity flag is clear. While that flag is set, later events leave the stored address unchanged.
- R5: An address-decode event, or a compare event in test mode, loads the uncorrectable address register (word 7) only while both the decode flag and the compare flag are clear.
- R6: A compare event sets the compare-logic flag and can load an address only while test_mode is high. With test_mode low the event has no effect.
- R7: Each single-bit event increments the 16-bit count (word 2). When the incremented value equals the threshold (word 1, bits 15:0), the threshold flag sets and the count returns to 0. The flag sets even when its interrupt is disabled.
- R8: Clearing the threshold flag drops irq_sbe, and a later threshold hit raises it again.
- R9: When a flag's event and a privileged clear of that flag arrive in the same cycle, the flag stays set.
- R10: Control bits are 0 for the single-bit interrupt, 1 for parity, 2 for address error and 3 for multi-bit error. Each interrupt is high exactly while one of its flags is set and its enable bit is 1. Parity covers both parity flags, and address error covers the decode and compare flags.
- R11: A multi-bit error event sets the multi-bit error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| test_mode | input | 1 | High while the address-compare self-test runs |
| sbe_evt | input | 1 | Corrected single-bit error pulse |
| mbe_evt | input | 1 | Uncorrectable multi-bit error pulse |
| rpar_evt | input | 1 | Read-address parity failure pulse |
| rpar_addr | input | CAP_AW | Address paired with rpar_evt |
| wpar_evt | input | 1 | Write-address parity failure pulse |
| wpar_addr | input | CAP_AW | Address paired with wpar_evt |
| adec_evt | input | 1 | Redundant address-decode mismatch pulse |
| cmp_evt | input | 1 | Compare-element self-test failure pulse |
| adec_addr | input | CAP_AW | Address paired with adec_evt or cmp_evt |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_widx | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| irq_sbe | output | 1 | Single-bit threshold interrupt |
| irq_parity | output | 1 | Address parity interrupt |
| irq_addr | output | 1 | Address-error interrupt |
| irq_mbe | output | 1 | Multi-bit error interrupt |

## Verification
The bench builds the unit with CNT_W = 16 and CAP_AW = 18. It programs a threshold of 3, so the counter reaches its hit point and returns to zero within a handful of pulses. The captured addresses use patterns that differ in both halves of the 18-bit field, so a truncated or stale capture shows up on a read. Test mode is toggled around compare events so that both the ignored case and the accepted case are reachable, and events are made to coincide with privileged clears.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  localparam int NFLAG  = 6;
  localparam int F_SBE  = 0;
  localparam int F_DEC  = 1;
  localparam int F_CMP  = 2;
  localparam int F_MBE  = 3;
  localparam int F_RPAR = 4;
  localparam int F_WPAR = 5;
  // status bit position of each flag; software decodes these positions
  localparam int FLAG_POS [NFLAG] = '{0, 2, 4, 5, 8, 9};
  localparam int CTL_W  = 4;
  localparam int C_SBE  = 0;
  localparam int C_PAR  = 1;
  localparam int C_ADR  = 2;
  localparam int C_MBE  = 3;

  typedef enum logic [2:0] {
    RG_CTRL = 3'd0,
    RG_THR  = 3'd1,
    RG_CNT  = 3'd2,
    RG_NONE = 3'd3,
    RG_STAT = 3'd4,
    RG_RCAP = 3'd5,
    RG_WCAP = 3'd6,
    RG_UCAP = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/memerr_flag.sv
module memerr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  logic flag_d;

  // an arriving event outranks a clear in the same cycle
  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
  p_fall_needs_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr));
endmodule

// File: rtl/memerr_sbe_ctr.sv
module memerr_sbe_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] count_q,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_inc = count_q + CNT_W'(1);
    hit     = evt && (cnt_inc == thr);
    cnt_en  = evt;
    cnt_d   = hit ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= cnt_d;
  end

  p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(count_q));
endmodule

// File: rtl/memerr_regs.sv
module memerr_regs
  import memerr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CAP_AW = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_priv,
  input  logic [2:0]        bus_widx,
  input  logic [31:0]       bus_wdata,
  input  logic [NFLAG-1:0]  flags,
  input  logic [CNT_W-1:0]  count,
  input  logic [CAP_AW-1:0] rcap,
  input  logic [CAP_AW-1:0] wcap,
  input  logic [CAP_AW-1:0] ucap,
  output logic [CTL_W-1:0]  ctrl_q,
  output logic [CNT_W-1:0]  thr_q,
  output logic [NFLAG-1:0]  clr_vec,
  output logic [31:0]       bus_rdata
);
  reg_idx_e         idx;
  logic             wr_ok;
  logic             ctrl_en;
  logic             thr_en;
  logic             stat_wr;
  logic [CTL_W-1:0] ctrl_d;
  logic [CNT_W-1:0] thr_d;
  logic [31:0]      stat_v;
  logic             unused_wd;

  assign idx       = reg_idx_e'(bus_widx);
  assign unused_wd = ^bus_wdata;

  always_comb begin
    wr_ok   = bus_sel && bus_wr && bus_priv;
    ctrl_en = wr_ok && (idx == RG_CTRL);
    thr_en  = wr_ok && (idx == RG_THR);
    stat_wr = wr_ok && (idx == RG_STAT);
    ctrl_d  = bus_wdata[CTL_W-1:0];
    thr_d   = bus_wdata[CNT_W-1:0];
    for (int i = 0; i < NFLAG; i++) clr_vec[i] = stat_wr && bus_wdata[FLAG_POS[i]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (thr_en) thr_q <= thr_d;
  end

  always_comb begin
    stat_v = '0;
    for (int i = 0; i < NFLAG; i++) stat_v[FLAG_POS[i]] = flags[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (idx)
        RG_CTRL: bus_rdata = 32'(ctrl_q);
        RG_THR:  bus_rdata = 32'(thr_q);
        RG_CNT:  bus_rdata = 32'(count);
        RG_STAT: bus_rdata = stat_v;
        RG_RCAP: bus_rdata = 32'(rcap);
        RG_WCAP: bus_rdata = 32'(wcap);
        RG_UCAP: bus_rdata = 32'(ucap);
        default: bus_rdata = '0;
      endcase
    end
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && idx == RG_STAT) |->
      (bus_rdata[31:10] == '0 && bus_rdata[7:6] == '0 && !bus_rdata[3] && !bus_rdata[1]));
  p_unpriv_no_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_priv |-> (clr_vec == '0));
endmodule

// File: rtl/memerr_status_unit.sv
module memerr_status_unit
  import memerr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CAP_AW = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              sbe_evt,
  input  logic              mbe_evt,
  input  logic              rpar_evt,
  input  logic [CAP_AW-1:0] rpar_addr,
  input  logic              wpar_evt,
  input  logic [CAP_AW-1:0] wpar_addr,
  input  logic              adec_evt,
  input  logic              cmp_evt,
  input  logic [CAP_AW-1:0] adec_addr,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_priv,
  input  logic [2:0]        bus_widx,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_sbe,
  output logic              irq_parity,
  output logic              irq_addr,
  output logic              irq_mbe
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_s;
  logic [NFLAG-1:0]  set_vec;
  logic [NFLAG-1:0]  clr_vec;
  logic [NFLAG-1:0]  flags;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  thr;
  logic              sbe_hit;
  logic [CTL_W-1:0]  ctrl;
  logic              cmp_ok;
  logic              unc_free;
  logic              rcap_en, wcap_en, ucap_en;
  logic [CAP_AW-1:0] rcap_q, wcap_q, ucap_q;
  logic [CAP_AW-1:0] ucap_d;

  // reset asserts at once and leaves on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_s = rst_pipe[SYNC_N-1];

  memerr_sbe_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst_n(rst_s), .evt(sbe_evt), .thr(thr),
    .count_q(count), .hit(sbe_hit)
  );

  always_comb begin
    cmp_ok          = cmp_evt && test_mode;
    set_vec         = '0;
    set_vec[F_SBE]  = sbe_hit;
    set_vec[F_DEC]  = adec_evt;
    set_vec[F_CMP]  = cmp_ok;
    set_vec[F_MBE]  = mbe_evt;
    set_vec[F_RPAR] = rpar_evt;
    set_vec[F_WPAR] = wpar_evt;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    memerr_flag flag_i (
      .clk(clk), .rst_n(rst_s), .set(set_vec[g]), .clr(clr_vec[g]),
      .flag_q(flags[g])
    );
  end

  // capture gating: the first fault address is kept until its flag is cleared
  always_comb begin
    unc_free = !flags[F_DEC] && !flags[F_CMP];
    rcap_en  = rpar_evt && !flags[F_RPAR];
    wcap_en  = wpar_evt && !flags[F_WPAR];
    ucap_en  = unc_free && (adec_evt || cmp_ok);
    ucap_d   = adec_addr;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       rcap_q <= '0;
    else if (rcap_en) rcap_q <= rpar_addr;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       wcap_q <= '0;
    else if (wcap_en) wcap_q <= wpar_addr;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       ucap_q <= '0;
    else if (ucap_en) ucap_q <= ucap_d;
  end

  memerr_regs #(.CNT_W(CNT_W), .CAP_AW(CAP_AW)) regs_i (
    .clk(clk), .rst_n(rst_s),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_priv(bus_priv),
    .bus_widx(bus_widx), .bus_wdata(bus_wdata),
    .flags(flags), .count(count),
    .rcap(rcap_q), .wcap(wcap_q), .ucap(ucap_q),
    .ctrl_q(ctrl), .thr_q(thr), .clr_vec(clr_vec), .bus_rdata(bus_rdata)
  );

  always_comb begin
    irq_sbe    = flags[F_SBE] && ctrl[C_SBE];
    irq_parity = (flags[F_RPAR] || flags[F_WPAR]) && ctrl[C_PAR];
    irq_addr   = (flags[F_DEC] || flags[F_CMP]) && ctrl[C_ADR];
    irq_mbe    = flags[F_MBE] && ctrl[C_MBE];
  end

  p_rcap_hold_r4: assert property (@(posedge clk) disable iff (!rst_s)
    flags[F_RPAR] |=> $stable(rcap_q));
  p_wcap_hold_r4: assert property (@(posedge clk) disable iff (!rst_s)
    flags[F_WPAR] |=> $stable(wcap_q));
  p_ucap_hold_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (flags[F_DEC] || flags[F_CMP]) |=> $stable(ucap_q));
  p_cmp_functional_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (!test_mode && !flags[F_CMP]) |=> !flags[F_CMP]);
  p_hit_resets_count_r7: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(flags[F_SBE]) |-> (count == '0));
  p_mbe_sets_r11: assert property (@(posedge clk) disable iff (!rst_s)
    mbe_evt |=> (flags[F_MBE] && $past(mbe_evt)));
endmodule

// File: tb/memerr_status_unit_tb_top.sv
`timescale 1ns/1ps
module memerr_status_unit_tb_top;
  localparam int CNT_W  = 16;
  localparam int CAP_AW = 18;

  logic              clk;
  logic              rst_n;
  logic              test_mode;
  logic              sbe_evt, mbe_evt, rpar_evt, wpar_evt, adec_evt, cmp_evt;
  logic [CAP_AW-1:0] rpar_addr, wpar_addr, adec_addr;
  logic              bus_sel, bus_wr, bus_priv;
  logic [2:0]        bus_widx;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic              irq_sbe, irq_parity, irq_addr, irq_mbe;

  memerr_status_unit #(.CNT_W(CNT_W), .CAP_AW(CAP_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .sbe_evt(sbe_evt), .mbe_evt(mbe_evt),
    .rpar_evt(rpar_evt), .rpar_addr(rpar_addr),
    .wpar_evt(wpar_evt), .wpar_addr(wpar_addr),
    .adec_evt(adec_evt), .cmp_evt(cmp_evt), .adec_addr(adec_addr),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_priv(bus_priv),
    .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_sbe(irq_sbe), .irq_parity(irq_parity), .irq_addr(irq_addr), .irq_mbe(irq_mbe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    string       tag;
    logic [31:0] exp;
    bit          is_irq;
  } item_t;

  item_t q[$];
  int    checks   = 0;
  int    failures = 0;
  bit    done     = 0;

  localparam logic [2:0] W_CTRL = 3'd0, W_THR = 3'd1, W_CNT = 3'd2, W_STAT = 3'd4,
                         W_RCAP = 3'd5, W_WCAP = 3'd6, W_UCAP = 3'd7;

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {28'd0, irq_mbe, irq_addr, irq_parity, irq_sbe} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk_rd(input logic [2:0] w, input logic [31:0] e, input string tag);
    item_t it;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_widx = w;
    it.tag = tag; it.exp = e; it.is_irq = 1'b0;
    q.push_back(it);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic chk_irq(input logic [3:0] e, input string tag);
    item_t it;
    it.tag = tag; it.exp = {28'd0, e}; it.is_irq = 1'b1;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d, input logic priv);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_priv = priv; bus_widx = w; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
  endtask

  // which: 0 sbe, 1 mbe, 2 rpar, 3 wpar, 4 adec, 5 cmp
  task automatic pulse(input int which, input logic [CAP_AW-1:0] a);
    rpar_addr = a; wpar_addr = a; adec_addr = a;
    case (which)
      0: sbe_evt  = 1'b1;
      1: mbe_evt  = 1'b1;
      2: rpar_evt = 1'b1;
      3: wpar_evt = 1'b1;
      4: adec_evt = 1'b1;
      default: cmp_evt = 1'b1;
    endcase
    @(posedge clk); #1;
    {sbe_evt, mbe_evt, rpar_evt, wpar_evt, adec_evt, cmp_evt} = '0;
  endtask

  initial begin
    rst_n = 1'b0; test_mode = 1'b0;
    {sbe_evt, mbe_evt, rpar_evt, wpar_evt, adec_evt, cmp_evt} = '0;
    rpar_addr = '0; wpar_addr = '0; adec_addr = '0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0; bus_widx = '0; bus_wdata = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;

    chk_rd(W_STAT, 32'h0, "R1 status after reset");
    chk_rd(W_CNT,  32'h0, "R1 count after reset");
    chk_rd(W_THR,  32'h0, "R1 threshold after reset");
    chk_rd(W_UCAP, 32'h0, "R1 capture after reset");
    chk_irq(4'h0, "R1 irqs after reset");

    wr(W_STAT, 32'hFFFF_FFFF, 1'b1);
    chk_rd(W_STAT, 32'h0, "R2 reserved bits stay zero");

    wr(W_THR, 32'h0000_0003, 1'b0);
    chk_rd(W_THR, 32'h0, "R3 unprivileged threshold write ignored");
    wr(W_THR, 32'h0000_0003, 1'b1);
    chk_rd(W_THR, 32'h3, "R7 threshold programmed");

    pulse(0, '0); pulse(0, '0);
    chk_rd(W_CNT,  32'h2, "R7 count after two events");
    chk_rd(W_STAT, 32'h0, "R7 flag below threshold");
    pulse(0, '0);
    chk_rd(W_STAT, 32'h1, "R7 flag at threshold");
    chk_rd(W_CNT,  32'h0, "R7 count restarts at threshold");
    chk_irq(4'h0, "R7 flag set with interrupt disabled");
    wr(W_CTRL, 32'h1, 1'b1);
    chk_irq(4'h1, "R10 single-bit irq enabled");
    wr(W_STAT, 32'h1, 1'b1);
    chk_rd(W_STAT, 32'h0, "R8 threshold flag cleared");
    chk_irq(4'h0, "R8 irq dropped by clear");
    pulse(0, '0); pulse(0, '0); pulse(0, '0);
    chk_irq(4'h1, "R8 irq re-raised after next hit");
    wr(W_STAT, 32'h1, 1'b1);

    pulse(2, 18'h2_5A55);
    chk_rd(W_STAT, 32'h100, "R2 read parity at bit 8");
    chk_rd(W_RCAP, 32'h2_5A55, "R4 read parity address captured");
    pulse(2, 18'h1_A5AA);
    chk_rd(W_RCAP, 32'h2_5A55, "R4 read parity address held");
    wr(W_STAT, 32'h100, 1'b0);
    chk_rd(W_STAT, 32'h100, "R3 unprivileged clear ignored");
    wr(W_STAT, 32'h0, 1'b1);
    chk_rd(W_STAT, 32'h100, "R3 writing zero keeps flag");
    wr(W_CTRL, 32'h3, 1'b1);
    chk_irq(4'h2, "R10 parity irq");
    wr(W_STAT, 32'hFFFF_FFFF, 1'b1);
    chk_rd(W_STAT, 32'h0, "R3 privileged clear");
    chk_irq(4'h0, "R10 parity irq drops");
    pulse(2, 18'h1_A5AA);
    chk_rd(W_RCAP, 32'h1_A5AA, "R4 capture re-armed");
    wr(W_STAT, 32'h100, 1'b1);

    pulse(3, 18'h3_C3C3);
    chk_rd(W_STAT, 32'h200, "R2 write parity at bit 9");
    pulse(3, 18'h0_0001);
    chk_rd(W_WCAP, 32'h3_C3C3, "R4 write parity address held");
    wr(W_STAT, 32'h200, 1'b1);

    test_mode = 1'b0;
    pulse(5, 18'h0_0077);
    chk_rd(W_STAT, 32'h0, "R6 compare ignored in functional mode");
    chk_rd(W_UCAP, 32'h0, "R6 no capture in functional mode");
    test_mode = 1'b1;
    pulse(5, 18'h2_0088);
    test_mode = 1'b0;
    chk_rd(W_STAT, 32'h10, "R6 compare flag in test mode");
    chk_rd(W_UCAP, 32'h2_0088, "R6 compare address captured");
    pulse(4, 18'h0_0099);
    chk_rd(W_STAT, 32'h14, "R2 decode fail at bit 2");
    chk_rd(W_UCAP, 32'h2_0088, "R5 held while compare flag set");
    wr(W_STAT, 32'h10, 1'b1);
    pulse(4, 18'h1_00AA);
    chk_rd(W_UCAP, 32'h2_0088, "R5 held while decode flag set");
    wr(W_CTRL, 32'h7, 1'b1);
    chk_irq(4'h4, "R10 address irq");
    wr(W_STAT, 32'h4, 1'b1);
    pulse(4, 18'h1_00AA);
    chk_rd(W_UCAP, 32'h1_00AA, "R5 decode address captured when free");
    wr(W_STAT, 32'h4, 1'b1);

    pulse(1, '0);
    chk_rd(W_STAT, 32'h20, "R11 multi-bit flag at bit 5");
    wr(W_CTRL, 32'hF, 1'b1);
    chk_irq(4'h8, "R10 multi-bit irq");

    bus_sel = 1'b1; bus_wr = 1'b1; bus_priv = 1'b1; bus_widx = W_STAT; bus_wdata = 32'h20;
    mbe_evt = 1'b1;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0; mbe_evt = 1'b0;
    chk_rd(W_STAT, 32'h20, "R9 event beats same-cycle clear");
    wr(W_STAT, 32'h20, 1'b1);
    chk_rd(W_STAT, 32'h0, "R9 later clear succeeds");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule